// File: doc/BRIEF.md
# Burst Transfer Size Calculator

This unit decides how many bytes each bus operation of a burst DMA transfer moves. A transfer is loaded with a source address, a destination address and a byte count. The unit then presents the size of the next bus operation. Each time the bus side acknowledges an operation, the unit advances the addresses, lowers the remaining count and works out the next size. When the count reaches zero it raises a done flag.

A small configuration register holds three settings: the sizing policy, the set size as a power-of-two code, and whether the transfer uses two addresses.

The **fixed** policy moves the set size on every operation and never forces alignment. If an operation would cross a 128-byte (32-word) boundary, it is cut at that boundary and the rest goes in the following operation.

The **aligned** policy picks the largest power of two, no larger than the set size, that keeps the addresses naturally aligned. In dual-address transfers, the aligned policy is only fully used when both addresses are word-aligned and the count is a multiple of four. Otherwise the unit falls back to word-or-smaller operations.

Top module: `burst_size_calc`

## Requirements
- R1: With the fixed policy (cfg_fixed=1), the operation size is 2^cfg_code bytes whenever neither the 128-byte boundary nor the remaining count limits it.
- R2: With the fixed policy, an address that is not aligned to the set size still gets a full set-size operation if no boundary lies in the way.
- R3: With the fixed policy, an operation that would cross a 128-byte boundary of the source (or, when dual, the destination) address ends exactly at that boundary. The next operation carries the rest of the set size.
- R4: With the aligned policy (cfg_fixed=0), the size is the largest power of two not above 2^cfg_code that divides the source address and, when dual, the destination address.
- R5: In a dual-address transfer with the aligned policy, if at start either address is not a multiple of 4 or the count is not a multiple of 4, no operation is larger than 4 bytes.
- R6: No operation is larger than the remaining count. With the aligned policy, the size is also a power of two not above that count.
- R7: On each acknowledged operation, the remaining count drops by the size and the source address rises by it. The destination address rises by it only when the transfer is dual.
- R8: When the remaining count reaches 0, busy falls and done rises. A start with a count of 0 gives done at once, with busy low.
- R9: Reset clears busy, done and the remaining count, and sets the configuration to aligned policy, code 0 (1 byte), single address.
- R10: An acknowledge while idle changes no address, count or flag.
- R11: A start loads a new transfer even while one is running, and clears done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe for the configuration register |
| cfg_fixed | input | 1 | Policy: 1 fixed, 0 aligned |
| cfg_dual | input | 1 | 1 when the transfer uses source and destination addresses |
| cfg_code | input | 3 | Set size code, size = 2^code bytes (1 to 128) |
| start | input | 1 | Load a new transfer |
| src_in | input | ADDR_W | Start source address |
| dst_in | input | ADDR_W | Start destination address |
| count_in | input | CNT_W | Byte count of the transfer |
| op_ack | input | 1 | The presented operation has been carried out |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | The last transfer has finished |
| op_size | output | 8 | Size in bytes of the next operation (0 when idle) |
| op_src | output | ADDR_W | Current source address |
| op_dst | output | ADDR_W | Current destination address |
| remaining | output | CNT_W | Bytes still to move |

## Verification
A wrong split remainder or a stale alignment flag shows up at op_size in the very next operation after the faulty one. A slip in the address or count registers shows up one cycle after the acknowledge, on op_src or remaining. Because every operation of every transfer is compared against an independent size model, an error cannot hide behind a correct total. The boundary cases need particular attention: a source sitting just below a 128-byte line, a destination misaligned only in the dual case, and a final short operation capped by the count. Each of these is a sequence in which one early wrong size shifts every later address.

// File: rtl/bsz_pkg.sv
package bsz_pkg;

    localparam int BLK_LG    = 7;
    localparam int BLK_BYTES = 1 << BLK_LG;
    localparam int CODE_W    = 3;
    localparam int SZ_W      = BLK_LG + 1;
    localparam int WORD_LG   = 2;

    typedef enum logic {
        POL_ALIGN = 1'b0,
        POL_FIXED = 1'b1
    } policy_e;

    typedef struct packed {
        policy_e             policy;
        logic                dual;
        logic [CODE_W-1:0]   code;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{policy: POL_ALIGN, dual: 1'b0, code: '0};

    // number of trailing zero bits inside one block offset, all-zero gives BLK_LG
    function automatic logic [CODE_W-1:0] low_zeros(input logic [BLK_LG-1:0] v);
        logic [CODE_W-1:0] r;
        r = CODE_W'(BLK_LG);
        for (int i = BLK_LG - 1; i >= 0; i--) begin
            if (v[i]) r = CODE_W'(i);
        end
        return r;
    endfunction

    // index of the highest set bit of a block-sized value
    function automatic logic [CODE_W-1:0] top_bit(input logic [BLK_LG-1:0] v);
        logic [CODE_W-1:0] r;
        r = '0;
        for (int i = 0; i < BLK_LG; i++) begin
            if (v[i]) r = CODE_W'(i);
        end
        return r;
    endfunction

    function automatic logic [CODE_W-1:0] code_min(input logic [CODE_W-1:0] a,
                                                   input logic [CODE_W-1:0] b);
        return (a < b) ? a : b;
    endfunction

    function automatic logic [SZ_W-1:0] size_min(input logic [SZ_W-1:0] a,
                                                 input logic [SZ_W-1:0] b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/bsz_align_path.sv
module bsz_align_path
    import bsz_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic [BLK_LG-1:0] src_lo,
    input  logic [BLK_LG-1:0] dst_lo,
    input  logic [CNT_W-1:0]  count,
    input  logic [CODE_W-1:0] code,
    input  logic              dual,
    input  logic              dual_ok,
    output logic [SZ_W-1:0]   size
);
    localparam logic [CODE_W-1:0] WORD_CODE = CODE_W'(WORD_LG);

    logic [CODE_W-1:0] cnt_code;
    logic [CODE_W-1:0] c_src;
    logic [CODE_W-1:0] c_dst;
    logic [CODE_W-1:0] c_fin;

    always_comb begin
        if (|count[CNT_W-1:BLK_LG]) cnt_code = CODE_W'(BLK_LG);
        else                         cnt_code = top_bit(count[BLK_LG-1:0]);
    end

    always_comb begin
        c_src = code_min(code, low_zeros(src_lo));
        c_dst = dual ? code_min(c_src, low_zeros(dst_lo)) : c_src;
        c_fin = code_min(c_dst, cnt_code);
        if (dual && !dual_ok) c_fin = code_min(c_fin, WORD_CODE);
    end

    assign size = SZ_W'(1) << c_fin;

endmodule

// File: rtl/bsz_fixed_path.sv
module bsz_fixed_path
    import bsz_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic [BLK_LG-1:0] src_lo,
    input  logic [BLK_LG-1:0] dst_lo,
    input  logic [CNT_W-1:0]  count,
    input  logic [CODE_W-1:0] code,
    input  logic              dual,
    input  logic [SZ_W-1:0]   carry,
    output logic [SZ_W-1:0]   size,
    output logic [SZ_W-1:0]   next_carry
);
    logic [SZ_W-1:0] base;
    logic [SZ_W-1:0] room_src;
    logic [SZ_W-1:0] room_dst;
    logic [SZ_W-1:0] lim;

    always_comb begin
        base     = (carry != '0) ? carry : (SZ_W'(1) << code);
        room_src = SZ_W'(BLK_BYTES) - {1'b0, src_lo};
        room_dst = SZ_W'(BLK_BYTES) - {1'b0, dst_lo};
        lim      = size_min(base, room_src);
        if (dual) lim = size_min(lim, room_dst);
        if (count < CNT_W'(lim)) size = count[SZ_W-1:0];
        else                     size = lim;
        next_carry = (base > size) ? (base - size) : '0;
    end

endmodule

// File: rtl/bsz_track.sv
module bsz_track
    import bsz_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] src_in,
    input  logic [ADDR_W-1:0] dst_in,
    input  logic [CNT_W-1:0]  count_in,
    input  logic              dual,
    input  logic              op_ack,
    input  logic [SZ_W-1:0]   size,
    input  logic [SZ_W-1:0]   next_carry,
    output logic [ADDR_W-1:0] src_q,
    output logic [ADDR_W-1:0] dst_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [SZ_W-1:0]   carry_q,
    output logic              dual_ok_q,
    output logic              busy_q,
    output logic              done_q
);
    logic last_op;
    logic start_ok;

    assign last_op  = (cnt_q == CNT_W'(size));
    assign start_ok = (src_in[WORD_LG-1:0] == '0) && (dst_in[WORD_LG-1:0] == '0)
                    && (count_in[WORD_LG-1:0] == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q     <= '0;
            dst_q     <= '0;
            cnt_q     <= '0;
            carry_q   <= '0;
            dual_ok_q <= 1'b0;
            busy_q    <= 1'b0;
            done_q    <= 1'b0;
        end else if (start) begin
            src_q     <= src_in;
            dst_q     <= dst_in;
            cnt_q     <= count_in;
            carry_q   <= '0;
            dual_ok_q <= start_ok;
            busy_q    <= (count_in != '0);
            done_q    <= (count_in == '0);
        end else if (busy_q && op_ack) begin
            src_q <= src_q + ADDR_W'(size);
            if (dual) dst_q <= dst_q + ADDR_W'(size);
            cnt_q <= cnt_q - CNT_W'(size);
            if (last_op) begin
                busy_q  <= 1'b0;
                done_q  <= 1'b1;
                carry_q <= '0;
            end else begin
                carry_q <= next_carry;
            end
        end
    end

endmodule

// File: rtl/burst_size_calc.sv
module burst_size_calc
    import bsz_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic              cfg_fixed,
    input  logic              cfg_dual,
    input  logic [2:0]        cfg_code,
    input  logic              start,
    input  logic [ADDR_W-1:0] src_in,
    input  logic [ADDR_W-1:0] dst_in,
    input  logic [CNT_W-1:0]  count_in,
    input  logic              op_ack,
    output logic              busy,
    output logic              done,
    output logic [7:0]        op_size,
    output logic [ADDR_W-1:0] op_src,
    output logic [ADDR_W-1:0] op_dst,
    output logic [CNT_W-1:0]  remaining
);
    cfg_t            cfg_q;
    logic [SZ_W-1:0] size_al;
    logic [SZ_W-1:0] size_fx;
    logic [SZ_W-1:0] carry_fx;
    logic [SZ_W-1:0] size_sel;
    logic [SZ_W-1:0] carry_sel;
    logic [SZ_W-1:0] carry_q;
    logic            dual_ok_q;
    logic            busy_q;
    logic            done_q;
    logic            fixed_sel;
    logic [ADDR_W-1:0] src_q;
    logic [ADDR_W-1:0] dst_q;
    logic [CNT_W-1:0]  cnt_q;

    always_ff @(posedge clk) begin
        if (rst)         cfg_q <= CFG_RESET;
        else if (cfg_wr) cfg_q <= '{policy: policy_e'(cfg_fixed), dual: cfg_dual, code: cfg_code};
    end

    assign fixed_sel = (cfg_q.policy == POL_FIXED);

    bsz_align_path #(.CNT_W(CNT_W)) u_align (
        .src_lo  (src_q[BLK_LG-1:0]),
        .dst_lo  (dst_q[BLK_LG-1:0]),
        .count   (cnt_q),
        .code    (cfg_q.code),
        .dual    (cfg_q.dual),
        .dual_ok (dual_ok_q),
        .size    (size_al)
    );

    bsz_fixed_path #(.CNT_W(CNT_W)) u_fixed (
        .src_lo     (src_q[BLK_LG-1:0]),
        .dst_lo     (dst_q[BLK_LG-1:0]),
        .count      (cnt_q),
        .code       (cfg_q.code),
        .dual       (cfg_q.dual),
        .carry      (carry_q),
        .size       (size_fx),
        .next_carry (carry_fx)
    );

    assign size_sel  = fixed_sel ? size_fx  : size_al;
    assign carry_sel = fixed_sel ? carry_fx : '0;

    bsz_track #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_track (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .src_in     (src_in),
        .dst_in     (dst_in),
        .count_in   (count_in),
        .dual       (cfg_q.dual),
        .op_ack     (op_ack),
        .size       (size_sel),
        .next_carry (carry_sel),
        .src_q      (src_q),
        .dst_q      (dst_q),
        .cnt_q      (cnt_q),
        .carry_q    (carry_q),
        .dual_ok_q  (dual_ok_q),
        .busy_q     (busy_q),
        .done_q     (done_q)
    );

    assign busy      = busy_q;
    assign done      = done_q;
    assign op_size   = busy_q ? size_sel : '0;
    assign op_src    = src_q;
    assign op_dst    = dst_q;
    assign remaining = cnt_q;

endmodule

// File: rtl/burst_size_calc_chk.sv
module burst_size_calc_chk #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 24
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              op_ack,
    input logic              busy,
    input logic              done,
    input logic              fixed_mode,
    input logic [7:0]        op_size,
    input logic [ADDR_W-1:0] op_src,
    input logic [CNT_W-1:0]  remaining
);
    logic [8:0] src_end;
    assign src_end = {2'b00, op_src[6:0]} + {1'b0, op_size};

    assert_size_fits_R6: assert property (@(posedge clk) disable iff (rst)
        busy |-> (op_size != 8'd0) && (CNT_W'(op_size) <= remaining));

    assert_count_step_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && op_ack && !start) |=> remaining == $past(remaining) - CNT_W'($past(op_size)));

    assert_src_step_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && op_ack && !start) |=> op_src == $past(op_src) + ADDR_W'($past(op_size)));

    assert_idle_ack_R10: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(remaining) && $stable(op_src));

    assert_done_state_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy && remaining == '0);

    assert_pow2_R4: assert property (@(posedge clk) disable iff (rst)
        (busy && !fixed_mode) |-> $countones(op_size) == 1);

    assert_no_cross_R3: assert property (@(posedge clk) disable iff (rst)
        (busy && fixed_mode) |-> src_end <= 9'd128);

endmodule

bind burst_size_calc burst_size_calc_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .op_ack     (op_ack),
    .busy       (busy),
    .done       (done),
    .fixed_mode (fixed_sel),
    .op_size    (op_size),
    .op_src     (op_src),
    .remaining  (remaining)
);

// File: tb/sim_burst_size_calc.sv
`timescale 1ns/1ps
module sim_burst_size_calc;

    localparam int ADDR_W = 32;
    localparam int CNT_W  = 24;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_wr = 1'b0;
    logic              cfg_fixed = 1'b0;
    logic              cfg_dual = 1'b0;
    logic [2:0]        cfg_code = '0;
    logic              start = 1'b0;
    logic [ADDR_W-1:0] src_in = '0;
    logic [ADDR_W-1:0] dst_in = '0;
    logic [CNT_W-1:0]  count_in = '0;
    logic              op_ack = 1'b0;
    logic              busy;
    logic              done;
    logic [7:0]        op_size;
    logic [ADDR_W-1:0] op_src;
    logic [ADDR_W-1:0] op_dst;
    logic [CNT_W-1:0]  remaining;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    burst_size_calc #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_fixed(cfg_fixed),
        .cfg_dual(cfg_dual), .cfg_code(cfg_code), .start(start),
        .src_in(src_in), .dst_in(dst_in), .count_in(count_in), .op_ack(op_ack),
        .busy(busy), .done(done), .op_size(op_size), .op_src(op_src),
        .op_dst(op_dst), .remaining(remaining)
    );

    typedef struct packed {
        logic        fixed;
        logic        dual;
        logic [2:0]  code;
        logic [31:0] src;
        logic [31:0] dst;
        logic [23:0] cnt;
        logic [7:0]  first;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 3'd5, 32'h1000, 32'h0,    24'd256, 8'd32}, // R4 aligned source
        '{1'b0, 1'b0, 3'd5, 32'h1004, 32'h0,    24'd256, 8'd4 }, // R4 word offset
        '{1'b0, 1'b0, 3'd5, 32'h1008, 32'h0,    24'd256, 8'd8 }, // R4 doubleword offset
        '{1'b0, 1'b1, 3'd5, 32'h1000, 32'h2010, 24'd256, 8'd16}, // R4 destination limits
        '{1'b0, 1'b1, 3'd5, 32'h1001, 32'h2000, 24'd64,  8'd1 }, // R5 odd source
        '{1'b0, 1'b1, 3'd5, 32'h1000, 32'h2000, 24'd66,  8'd4 }, // R5 count not word multiple
        '{1'b0, 1'b0, 3'd7, 32'h0,    32'h0,    24'd48,  8'd32}, // R6 count caps aligned size
        '{1'b1, 1'b0, 3'd5, 32'h1070, 32'h0,    24'd256, 8'd16}, // R3 split at line
        '{1'b1, 1'b0, 3'd5, 32'h1003, 32'h0,    24'd256, 8'd32}, // R2 unaligned full size
        '{1'b1, 1'b1, 3'd6, 32'h1000, 32'h20F0, 24'd200, 8'd16}, // R3 destination split
        '{1'b1, 1'b0, 3'd5, 32'h0,    32'h0,    24'd20,  8'd20}, // R6 count caps fixed size
        '{1'b1, 1'b0, 3'd7, 32'h40,   32'h0,    24'd512, 8'd64}, // R3 largest set size
        '{1'b1, 1'b0, 3'd4, 32'h100,  32'h0,    24'd64,  8'd16}  // R1 plain fixed size
    };

    function automatic string vec_req(input int i);
        case (i)
            0, 1, 2, 3: return "R4";
            4, 5:       return "R5";
            6, 10:      return "R6";
            8:          return "R2";
            12:         return "R1";
            default:    return "R3";
        endcase
    endfunction

    // reference model state
    longint unsigned m_src, m_dst, m_cnt, m_carry;
    bit m_ok;

    function automatic longint unsigned model_size(input bit fixed, input bit dual,
            input bit ok, input int code, input longint unsigned s_a,
            input longint unsigned d_a, input longint unsigned cnt,
            input longint unsigned carry, output longint unsigned ncarry);
        longint unsigned s, base, room;
        if (fixed) begin
            base = (carry != 0) ? carry : (64'd1 << code);
            s = base;
            room = 128 - (s_a % 128);
            if (room < s) s = room;
            if (dual) begin
                room = 128 - (d_a % 128);
                if (room < s) s = room;
            end
            if (cnt < s) s = cnt;
            ncarry = (base > s) ? base - s : 0;
        end else begin
            s = 64'd1 << code;
            if (dual && !ok && s > 4) s = 4;
            while (s > 1 && ((s_a % s) != 0 || (dual && (d_a % s) != 0) || s > cnt))
                s = s >> 1;
            ncarry = 0;
        end
        return s;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint unsigned act, input longint unsigned exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic write_cfg(input bit fixed, input bit dual, input logic [2:0] code);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_fixed = fixed; cfg_dual = dual; cfg_code = code;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic do_start(input logic [31:0] s, input logic [31:0] d, input logic [23:0] c);
        @(negedge clk);
        start = 1'b1; src_in = s; dst_in = d; count_in = c;
        @(negedge clk);
        start = 1'b0;
        m_src = s; m_dst = d; m_cnt = c; m_carry = 0;
        m_ok = (s[1:0] == 2'b00) && (d[1:0] == 2'b00) && (c[1:0] == 2'b00);
    endtask

    task automatic do_ack();
        op_ack = 1'b1;
        @(negedge clk);
        op_ack = 1'b0;
    endtask

    task automatic run_to_end(input bit fixed, input bit dual, input int code);
        longint unsigned s, nc;
        string rq;
        rq = fixed ? "R1" : "R4";
        for (int n = 0; n < 1000 && m_cnt != 0; n++) begin
            s = model_size(fixed, dual, m_ok, code, m_src, m_dst, m_cnt, m_carry, nc);
            check(op_size == 8'(s), rq, "op size", op_size, s);
            do_ack();
            m_src = m_src + s;
            if (dual) m_dst = m_dst + s;
            m_cnt = m_cnt - s;
            m_carry = nc;
            check(remaining == 24'(m_cnt) && op_src == 32'(m_src) && op_dst == 32'(m_dst),
                  "R7", "count/address after ack", {remaining, op_src}, {m_cnt[23:0], m_src[31:0]});
        end
        check(done && !busy, "R8", "done at end", {done, busy}, 2'b10);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired, run hung");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        longint unsigned src_hold;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        check(!busy && !done && remaining == '0 && op_size == 8'd0, "R9", "reset outputs",
              {busy, done, remaining}, 0);
        // R9 reset configuration: aligned, 1 byte, single
        do_start(32'h11, 32'h0, 24'd3);
        check(op_size == 8'd1, "R9", "reset code size", op_size, 1);
        run_to_end(1'b0, 1'b0, 0);

        // table of vectors
        for (int i = 0; i < NV; i++) begin
            write_cfg(VECS[i].fixed, VECS[i].dual, VECS[i].code);
            do_start(VECS[i].src, VECS[i].dst, VECS[i].cnt);
            check(op_size == VECS[i].first, vec_req(i), "first op size", op_size, VECS[i].first);
            run_to_end(VECS[i].fixed, VECS[i].dual, int'(VECS[i].code));
        end

        // R10 ack while idle
        src_hold = op_src;
        do_ack();
        check(remaining == '0 && op_src == 32'(src_hold) && done && !busy, "R10",
              "idle ack", op_src, src_hold);

        // R3 explicit split sequence: 16 then 16 then 32
        write_cfg(1'b1, 1'b0, 3'd5);
        do_start(32'h1070, 32'h0, 24'd64);
        check(op_size == 8'd16, "R3", "split first part", op_size, 16);
        do_ack();
        check(op_size == 8'd16 && op_src == 32'h1080, "R3", "split remainder", op_size, 16);
        do_ack();
        check(op_size == 8'd32, "R3", "full size after split", op_size, 32);

        // R11 restart while busy
        check(busy, "R11", "busy before restart", busy, 1);
        do_start(32'h2000, 32'h0, 24'd100);
        check(remaining == 24'd100 && op_src == 32'h2000 && busy && !done, "R11",
              "restart loads", remaining, 100);
        run_to_end(1'b1, 1'b0, 5);

        // R8 zero count start, R11 done cleared by start
        do_start(32'h0, 32'h0, 24'd0);
        check(done && !busy && op_size == 8'd0, "R8", "zero count", {done, busy}, 2'b10);
        do_start(32'h0, 32'h0, 24'd8);
        check(!done && busy, "R11", "start clears done", {done, busy}, 2'b01);
        run_to_end(1'b1, 1'b0, 5);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule